// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates a 32-bit effective address by searching a page table held in memory and organised as hashed groups of entries. A request carries the address, whether the access is a store, and whether it comes from user mode. The walker takes a segment descriptor from a local file of sixteen, forms a compare tag and a hash, and reads candidate entries through a simple single-cycle memory port. It scans the primary group first and then the secondary group at the complemented hash.

On a hit it decides the access rights from the entry's protection code and the segment's key. It sets the referenced bit, and sets the changed bit on a permitted store. The second word of the entry goes back to memory only when one of those bits was newly set. While the changed bit is still clear, write permission is withheld from the returned rights, so the first real store to a clean page comes back through the walker. The table origin and the hash mask are taken from a configuration load.

Top module: `hpt_walker`

## Requirements
- R1: Segment descriptor `s` is loaded from `seg_data` when `seg_we` is high and `seg_idx`=s. The descriptor used by a lookup is the one indexed by `req_ea[31:28]`. In a descriptor, bits [23:0] are the segment ID, bit 30 is the privileged key and bit 29 is the user key.
- R2: Let page index p = `req_ea[27:12]` and hash h = segID[18:0] XOR p. The group address is origin OR ((h << 6) AND mask). Entry k lies at group + 8k, with its first word at +0 and its second word at +4. Every memory read and write uses such an address.
- R3: The first entry word has valid in bit 31, the segment ID in bits [30:7], the secondary flag in bit 6 and p[15:10] in bits [5:0]. An entry matches only if it is valid, its flag equals the current pass, and its bits [30:7] and [5:0] equal the segment ID and p[15:10].
- R4: Entries are read in order 0..7, first from the primary group (pass 0, hash h) and then from the secondary group (pass 1, hash ~h). The first match wins and stops the scan. The number of first-word reads is the position of the match in that order.
- R5: If neither group holds a match after all 16 first-word reads, the response carries status 1 (not found), rights 0 and page number 0, and no memory write is made.
- R6: The key is the user key when `req_user`=1 and the privileged key otherwise. With key 0, protection code (second word bits [1:0]) 0, 1 or 2 grants read+write and code 3 grants read only. With key 1, code 0 grants nothing, code 2 grants read+write, and codes 1 and 3 grant read only. A load needs read and a store needs write; when the needed right is missing the status is 2 (denied), otherwise 0 (ok).
- R7: Any hit, including a denied one, sets the referenced bit (second word bit 8). A permitted store also sets the changed bit (bit 7).
- R8: `rsp_prot` (bit 0 read, bit 1 write) carries the granted rights, but with the write bit cleared whenever the changed bit is still clear after the access.
- R9: The second word is written back exactly once, with the updated bits, when the referenced or changed bit was newly set, and is not written otherwise.
- R10: `req_ready` is high only while idle, and a request is taken when `req_valid` is high then. `rsp_valid` is a single-cycle pulse carrying `rsp_status`, `rsp_prot`, and `rsp_rpn` = second word bits [31:12]. After reset the walker is idle with no memory request.
- R11: A high `cfg_load` captures `cfg_base` and `cfg_mask` as origin and mask, and later lookups address the table through the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_load | input | 1 | Capture table origin and mask |
| cfg_base | input | 32 | Table origin |
| cfg_mask | input | 32 | Group offset mask |
| seg_we | input | 1 | Segment descriptor write |
| seg_idx | input | 4 | Descriptor index |
| seg_data | input | 32 | Descriptor value |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Walker idle |
| req_ea | input | 32 | Effective address |
| req_store | input | 1 | Access is a store |
| req_user | input | 1 | Access from user mode |
| rsp_valid | output | 1 | Response pulse |
| rsp_status | output | 2 | 0 ok, 1 not found, 2 denied |
| rsp_rpn | output | 20 | Real page number |
| rsp_prot | output | 2 | Bit 0 read, bit 1 write |
| mem_req | output | 1 | Memory access |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
Some properties are checked on every cycle. Every memory address stays inside the window set by origin and mask. Every write-back carries the referenced bit. A response is a lone pulse while the walker is busy. A permitted store always returns write permission. A not-found result only follows the secondary pass. The bench scenarios cover what a property cannot show. They check the exact scan order through the count of reads, and that decoy entries are skipped: a wrong secondary flag, a cleared valid bit. They also check the protection table under both keys, the change of the stored word across a first load, a first store and a repeat access, and addressing after a mask reload.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
   typedef enum logic [2:0] {
      S_IDLE, S_RD0, S_CHK0, S_RD1, S_EVAL, S_WB, S_RESP
   } walk_state_e;

   localparam logic [1:0] ST_OK   = 2'd0;
   localparam logic [1:0] ST_MISS = 2'd1;
   localparam logic [1:0] ST_DENY = 2'd2;

   localparam int W0_VALID = 31;
   localparam int W0_SEC   = 6;
   localparam int W1_REF   = 8;
   localparam int W1_CHG   = 7;

   // rights as {write, read}
   function automatic logic [1:0] pp_rights(input logic key, input logic [1:0] pp);
      logic [1:0] r;
      if (!key) r = (pp == 2'd3) ? 2'b01 : 2'b11;
      else begin
         case (pp)
            2'd0:    r = 2'b00;
            2'd2:    r = 2'b11;
            default: r = 2'b01;
         endcase
      end
      return r;
   endfunction
endpackage

// File: rtl/hpt_segfile.sv
module hpt_segfile #(
   parameter int NSEG   = 16,
   parameter int VSID_W = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [$clog2(NSEG)-1:0] wr_idx,
   input  logic [VSID_W-1:0]       wr_vsid,
   input  logic                    wr_skey,
   input  logic                    wr_ukey,
   input  logic [$clog2(NSEG)-1:0] rd_idx,
   output logic [VSID_W-1:0]       rd_vsid,
   output logic                    rd_skey,
   output logic                    rd_ukey
);
   localparam int IDX_W = $clog2(NSEG);
   localparam int ENT_W = VSID_W + 2;

   logic [ENT_W-1:0] seg_r [NSEG];

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            seg_r[g] <= '0;
         else if (wr_en && wr_idx == IDX_W'(g))
            seg_r[g] <= {wr_skey, wr_ukey, wr_vsid};
      end
   end

   assign rd_vsid = seg_r[rd_idx][VSID_W-1:0];
   assign rd_ukey = seg_r[rd_idx][VSID_W];
   assign rd_skey = seg_r[rd_idx][VSID_W+1];
endmodule

// File: rtl/hpt_hash.sv
module hpt_hash #(
   parameter int VSID_W        = 24,
   parameter int HASH_W        = 19,
   parameter int PGIDX_W       = 16,
   parameter int API_W         = 6,
   parameter int GROUP_ENTRIES = 8,
   parameter int ENTRY_BYTES   = 8
) (
   input  logic [VSID_W-1:0]                  vsid,
   input  logic [PGIDX_W-1:0]                 pidx,
   input  logic                               pass,
   input  logic [$clog2(GROUP_ENTRIES)-1:0]   slot,
   input  logic                               word_hi,
   input  logic [31:0]                        base,
   input  logic [31:0]                        mask,
   output logic [VSID_W+API_W:0]              tag,
   output logic [31:0]                        addr
);
   localparam int GROUP_SH = $clog2(GROUP_ENTRIES * ENTRY_BYTES);
   localparam int ENTRY_SH = $clog2(ENTRY_BYTES);

   if (HASH_W > VSID_W || HASH_W < PGIDX_W) begin : g_bad_hash
      $error("hash width must lie between page index and segment ID widths");
   end

   logic [HASH_W-1:0] hash, hsel;
   logic [31:0]       grp;

   assign hash = vsid[HASH_W-1:0] ^ HASH_W'(pidx);
   assign hsel = pass ? ~hash : hash;
   assign grp  = (32'(hsel) << GROUP_SH) & mask;
   assign addr = base | grp | (32'(slot) << ENTRY_SH) | (word_hi ? 32'd4 : 32'd0);
   assign tag  = {vsid, 1'b0, pidx[PGIDX_W-1 -: API_W]};
endmodule

// File: rtl/hpt_prot.sv
module hpt_prot
   import hpt_pkg::*;
(
   input  logic        key,
   input  logic        store,
   input  logic [31:0] w1,
   output logic [31:0] w1_new,
   output logic [1:0]  prot,
   output logic        deny,
   output logic        dirty
);
   logic [1:0] raw;

   always_comb begin
      raw    = pp_rights(key, w1[1:0]);
      deny   = store ? !raw[1] : !raw[0];
      w1_new = w1;
      w1_new[W1_REF] = 1'b1;
      if (store && !deny) w1_new[W1_CHG] = 1'b1;
      prot = raw;
      if (!w1_new[W1_CHG]) prot[1] = 1'b0;
      dirty = (w1_new != w1);
   end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
   import hpt_pkg::*;
#(
   parameter int SEG_BITS      = 4,
   parameter int PAGE_BITS     = 12,
   parameter int VSID_W        = 24,
   parameter int HASH_W        = 19,
   parameter int GROUP_ENTRIES = 8,
   parameter int ENTRY_BYTES   = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_load,
   input  logic [31:0] cfg_base,
   input  logic [31:0] cfg_mask,
   input  logic        seg_we,
   input  logic [3:0]  seg_idx,
   input  logic [31:0] seg_data,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [31:0] req_ea,
   input  logic        req_store,
   input  logic        req_user,
   output logic        rsp_valid,
   output logic [1:0]  rsp_status,
   output logic [19:0] rsp_rpn,
   output logic [1:0]  rsp_prot,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic [31:0] mem_rdata
);
   localparam int NSEG    = 1 << SEG_BITS;
   localparam int PGIDX_W = 32 - SEG_BITS - PAGE_BITS;
   localparam int API_W   = PGIDX_W - 10;
   localparam int TAG_W   = VSID_W + API_W + 1;
   localparam int SLOT_W  = $clog2(GROUP_ENTRIES);
   localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_ENTRIES - 1);

   if (TAG_W != 31 || ENTRY_BYTES != 8 || SEG_BITS != 4 || PAGE_BITS != 12) begin : g_bad_fmt
      $error("entry format needs a 31-bit tag, 8-byte entries, 4 segment bits, 4 KB pages");
   end
   if ((1 << SLOT_W) != GROUP_ENTRIES) begin : g_bad_group
      $error("group entry count must be a power of two");
   end

   walk_state_e         state;
   logic [31:0]         base_q, mask_q, w1_q;
   logic [PGIDX_W-1:0]  pidx_q;
   logic [VSID_W-1:0]   vsid_q;
   logic                key_q, store_q, pass_q;
   logic [SLOT_W-1:0]   slot_q;
   logic [1:0]          status_q, prot_q;

   logic [VSID_W-1:0]   seg_vsid;
   logic                seg_skey, seg_ukey;
   logic [TAG_W-1:0]    tag;
   logic [31:0]         ent_addr, w1_new;
   logic [1:0]          prot_new;
   logic                deny, dirty, hit;

   hpt_segfile #(.NSEG(NSEG), .VSID_W(VSID_W)) u_seg (
      .clk(clk), .rst_n(rst_n),
      .wr_en(seg_we), .wr_idx(seg_idx),
      .wr_vsid(seg_data[VSID_W-1:0]), .wr_skey(seg_data[30]), .wr_ukey(seg_data[29]),
      .rd_idx(req_ea[31 -: SEG_BITS]),
      .rd_vsid(seg_vsid), .rd_skey(seg_skey), .rd_ukey(seg_ukey)
   );

   hpt_hash #(
      .VSID_W(VSID_W), .HASH_W(HASH_W), .PGIDX_W(PGIDX_W), .API_W(API_W),
      .GROUP_ENTRIES(GROUP_ENTRIES), .ENTRY_BYTES(ENTRY_BYTES)
   ) u_hash (
      .vsid(vsid_q), .pidx(pidx_q), .pass(pass_q), .slot(slot_q),
      .word_hi(state == S_RD1 || state == S_WB),
      .base(base_q), .mask(mask_q), .tag(tag), .addr(ent_addr)
   );

   hpt_prot u_prot (
      .key(key_q), .store(store_q), .w1(mem_rdata),
      .w1_new(w1_new), .prot(prot_new), .deny(deny), .dirty(dirty)
   );

   assign hit = mem_rdata[W0_VALID] && (mem_rdata[W0_SEC] == pass_q) &&
                ({mem_rdata[30:W0_SEC+1], 1'b0, mem_rdata[W0_SEC-1:0]} == tag);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         base_q   <= '0;
         mask_q   <= '0;
         w1_q     <= '0;
         pidx_q   <= '0;
         vsid_q   <= '0;
         key_q    <= 1'b0;
         store_q  <= 1'b0;
         pass_q   <= 1'b0;
         slot_q   <= '0;
         status_q <= ST_OK;
         prot_q   <= '0;
      end else begin
         if (cfg_load) begin
            base_q <= cfg_base;
            mask_q <= cfg_mask;
         end
         case (state)
            S_IDLE: if (req_valid) begin
               pidx_q  <= req_ea[31-SEG_BITS:PAGE_BITS];
               vsid_q  <= seg_vsid;
               key_q   <= req_user ? seg_ukey : seg_skey;
               store_q <= req_store;
               pass_q  <= 1'b0;
               slot_q  <= '0;
               state   <= S_RD0;
            end
            S_RD0: state <= S_CHK0;
            S_CHK0: begin
               if (hit) state <= S_RD1;
               else if (slot_q != LAST_SLOT) begin
                  slot_q <= slot_q + 1'b1;
                  state  <= S_RD0;
               end else if (!pass_q) begin
                  pass_q <= 1'b1;
                  slot_q <= '0;
                  state  <= S_RD0;
               end else begin
                  status_q <= ST_MISS;
                  prot_q   <= '0;
                  w1_q     <= '0;
                  state    <= S_RESP;
               end
            end
            S_RD1: state <= S_EVAL;
            S_EVAL: begin
               w1_q     <= w1_new;
               prot_q   <= prot_new;
               status_q <= deny ? ST_DENY : ST_OK;
               state    <= dirty ? S_WB : S_RESP;
            end
            S_WB:    state <= S_RESP;
            S_RESP:  state <= S_IDLE;
            default: state <= S_IDLE;
         endcase
      end
   end

   assign req_ready  = (state == S_IDLE);
   assign rsp_valid  = (state == S_RESP);
   assign rsp_status = status_q;
   assign rsp_prot   = prot_q;
   assign rsp_rpn    = w1_q[31:PAGE_BITS];
   assign mem_req    = (state == S_RD0) || (state == S_RD1) || (state == S_WB);
   assign mem_we     = (state == S_WB);
   assign mem_addr   = ent_addr;
   assign mem_wdata  = w1_q;

   // R2: every access falls inside the table window
   a_r2_table_window: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (((mem_addr ^ base_q) & ~(mask_q | 32'h3F)) == 32'h0));
   // R7: a written-back word always carries the referenced bit
   a_r7_wb_ref: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[W1_REF]);
   // R10: responses are single-cycle pulses while busy
   a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);
   a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);
   // R8: an accepted store returns write permission
   a_r8_store_write: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == ST_OK && store_q) |-> rsp_prot[1]);
   // R5: not found only after the secondary pass
   a_r5_miss_secondary: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == ST_MISS) |-> (pass_q && rsp_prot == 2'b00));
endmodule

// File: tb/hpt_walker_test.sv
module hpt_walker_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_load;
   logic [31:0] cfg_base, cfg_mask;
   logic        seg_we;
   logic [3:0]  seg_idx;
   logic [31:0] seg_data;
   logic        req_valid, req_ready, req_store, req_user;
   logic [31:0] req_ea;
   logic        rsp_valid;
   logic [1:0]  rsp_status, rsp_prot;
   logic [19:0] rsp_rpn;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;

   int checks = 0, fails = 0, rd_cnt = 0, wr_cnt = 0;
   bit done = 0;
   logic [31:0] mem [int unsigned];
   logic [31:0] segs [16];
   logic [31:0] b_base, b_mask;

   always #(CLK_PERIOD/2) clk = ~clk;

   hpt_walker uut (.*);

   function automatic logic [31:0] memrd(input logic [31:0] a);
      int unsigned k = a >> 2;
      return mem.exists(k) ? mem[k] : 32'h0;
   endfunction

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            mem[mem_addr >> 2] = mem_wdata;
            wr_cnt++;
         end else begin
            mem_rdata <= memrd(mem_addr);
            rd_cnt++;
         end
      end
   end

   task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   function automatic logic [31:0] grp_of(input logic [31:0] ea, input logic sec);
      logic [18:0] h = segs[ea[31:28]][18:0] ^ {3'b0, ea[27:12]};
      if (sec) h = ~h;
      return b_base | ((32'(h) << 6) & b_mask);
   endfunction

   function automatic logic [31:0] w0_of(input logic [31:0] ea, input logic sec, input logic v);
      return {v, segs[ea[31:28]][23:0], sec, ea[27:22]};
   endfunction

   function automatic logic [31:0] w1_of(input logic [19:0] rpn, input logic r, input logic c, input logic [1:0] pp);
      return {rpn, 3'b0, r, c, 5'b0, pp};
   endfunction

   task automatic put(input logic [31:0] grp, input int slot, input logic [31:0] w0, input logic [31:0] w1);
      mem[(grp + 32'(slot) * 8) >> 2]     = w0;
      mem[(grp + 32'(slot) * 8 + 4) >> 2] = w1;
   endtask

   task automatic model(input logic [31:0] ea, input logic st, input logic usr,
                        output logic [1:0] status, output logic [19:0] rpn, output logic [1:0] prot,
                        output logic [31:0] w1n, output logic [31:0] w1a, output int rd, output int wr);
      logic [31:0] sr = segs[ea[31:28]];
      logic found = 0;
      logic [31:0] fa = 0, w0, w1;
      logic key;
      logic [1:0] rt;
      logic bad;
      rd = 0; wr = 0; status = 2'd1; rpn = 0; prot = 0; w1n = 0; w1a = 0;
      for (int p = 0; p < 2; p++)
         for (int s = 0; s < 8; s++)
            if (!found) begin
               rd++;
               w0 = memrd(grp_of(ea, p[0]) + 32'(s) * 8);
               if (w0[31] && w0[6] == p[0] && w0[30:7] == sr[23:0] && w0[5:0] == ea[27:22]) begin
                  found = 1;
                  fa = grp_of(ea, p[0]) + 32'(s) * 8;
               end
            end
      if (found) begin
         rd++;
         w1a = fa + 4;
         w1  = memrd(w1a);
         key = usr ? sr[29] : sr[30];
         if (!key) rt = (w1[1:0] == 2'd3) ? 2'b01 : 2'b11;
         else rt = (w1[1:0] == 2'd0) ? 2'b00 : (w1[1:0] == 2'd2) ? 2'b11 : 2'b01;
         bad = st ? !rt[1] : !rt[0];
         w1n = w1;
         w1n[8] = 1'b1;
         if (st && !bad) w1n[7] = 1'b1;
         prot = w1n[7] ? rt : {1'b0, rt[0]};
         status = bad ? 2'd2 : 2'd0;
         rpn = w1[31:12];
         wr = (w1n != w1) ? 1 : 0;
      end
   endtask

   task automatic lookup(input string rq, input logic [31:0] ea, input logic st, input logic usr);
      logic [1:0] es, ep;
      logic [19:0] er;
      logic [31:0] ew, ea1;
      int erd, ewr, rd0, wr0, guard;
      model(ea, st, usr, es, er, ep, ew, ea1, erd, ewr);
      while (!req_ready) @(negedge clk);
      rd0 = rd_cnt; wr0 = wr_cnt;
      req_valid = 1; req_ea = ea; req_store = st; req_user = usr;
      @(negedge clk);
      req_valid = 0;
      chk("R10", "ready while busy", 32'(req_ready), 32'h0);
      guard = 0;
      while (!rsp_valid && guard < 200) begin
         @(negedge clk);
         guard++;
      end
      chk(rq, "status", 32'(rsp_status), 32'(es));
      chk(rq, "rpn", 32'(rsp_rpn), 32'(er));
      chk(rq, "prot", 32'(rsp_prot), 32'(ep));
      chk(rq, "reads", 32'(rd_cnt - rd0), 32'(erd));
      chk("R9", "writes", 32'(wr_cnt - wr0), 32'(ewr));
      if (es != 2'd1) chk("R7", "stored word", memrd(ea1), ew);
      @(negedge clk);
      chk("R10", "pulse ends", 32'(rsp_valid), 32'h0);
   endtask

   task automatic wr_seg(input int i, input logic [31:0] v);
      seg_we = 1; seg_idx = 4'(i); seg_data = v; segs[i] = v;
      @(negedge clk);
      seg_we = 0;
   endtask

   task automatic load_cfg(input logic [31:0] b, input logic [31:0] m);
      cfg_load = 1; cfg_base = b; cfg_mask = m; b_base = b; b_mask = m;
      @(negedge clk);
      cfg_load = 0;
   endtask

   task automatic t_reset;
      chk("R10", "reset ready", 32'(req_ready), 32'h1);
      chk("R10", "reset rsp", 32'(rsp_valid), 32'h0);
      chk("R10", "reset mem", 32'(mem_req), 32'h0);
   endtask

   // R7 R8 R9: first load, first store, repeat access on one page
   task automatic t_ref_change;
      logic [31:0] ea = 32'h0123_4000;
      put(grp_of(ea, 0), 1, w0_of(ea, 0, 1), w1_of(20'hABCDE, 0, 0, 2'd2));
      lookup("R8", ea, 0, 0);
      chk("R8", "write withheld", 32'(rsp_prot), 32'h1);
      lookup("R7", ea, 1, 0);
      lookup("R9", ea, 0, 0);
   endtask

   // R3 R4: decoys skipped, secondary pass found
   task automatic t_secondary;
      logic [31:0] ea = 32'h2345_6000;
      put(grp_of(ea, 0), 2, w0_of(ea, 1, 1), w1_of(20'h11111, 1, 1, 2'd2));
      put(grp_of(ea, 0), 5, w0_of(ea, 0, 0), w1_of(20'h22222, 1, 1, 2'd2));
      put(grp_of(ea, 1), 3, w0_of(ea, 1, 1), w1_of(20'h33333, 1, 1, 2'd2));
      lookup("R4", ea, 0, 0);
      chk("R3", "secondary rpn", 32'(rsp_rpn), 32'h33333);
   endtask

   task automatic t_last_slot;
      logic [31:0] ea = 32'h0555_5000;
      put(grp_of(ea, 0), 7, w0_of(ea, 0, 1), w1_of(20'h0F0F0, 1, 1, 2'd0));
      lookup("R2", ea, 1, 0);
   endtask

   task automatic t_miss;
      lookup("R5", 32'h1777_7000, 0, 1);
      chk("R5", "miss status", 32'(rsp_status), 32'h1);
   endtask

   // R1 R6: key choice and protection codes
   task automatic t_protect;
      logic [31:0] e1 = 32'h1111_1000, e2 = 32'h1222_2000, e3 = 32'h1333_3000, e4 = 32'h1444_4000;
      put(grp_of(e1, 0), 0, w0_of(e1, 0, 1), w1_of(20'h00001, 0, 0, 2'd1));
      put(grp_of(e2, 0), 4, w0_of(e2, 0, 1), w1_of(20'h00002, 1, 0, 2'd0));
      put(grp_of(e3, 0), 6, w0_of(e3, 0, 1), w1_of(20'h00003, 1, 1, 2'd3));
      put(grp_of(e4, 0), 3, w0_of(e4, 0, 1), w1_of(20'h00004, 0, 0, 2'd1));
      lookup("R6", e1, 1, 1);
      chk("R6", "user store deny", 32'(rsp_status), 32'h2);
      lookup("R6", e2, 0, 1);
      lookup("R1", e3, 1, 0);
      lookup("R1", e4, 0, 0);
   endtask

   task automatic t_cfg;
      logic [31:0] ea = 32'h0666_6000;
      load_cfg(32'h0020_0000, 32'h0000_3FC0);
      put(grp_of(ea, 0), 0, w0_of(ea, 0, 1), w1_of(20'h5A5A5, 1, 1, 2'd2));
      lookup("R11", ea, 0, 0);
      chk("R11", "new table rpn", 32'(rsp_rpn), 32'h5A5A5);
   endtask

   initial begin
      rst_n = 0; cfg_load = 0; cfg_base = 0; cfg_mask = 0; seg_we = 0; seg_idx = 0;
      seg_data = 0; req_valid = 0; req_ea = 0; req_store = 0; req_user = 0;
      for (int i = 0; i < 16; i++) segs[i] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      load_cfg(32'h0010_0000, 32'h0000_FFC0);
      wr_seg(0, 32'h0000_0456);
      wr_seg(1, 32'h2000_0123);
      wr_seg(2, 32'h6000_0000 | 32'h000A_BCDE);
      t_ref_change();
      t_secondary();
      t_last_slot();
      t_miss();
      t_protect();
      t_cfg();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog R10 actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule